// File: doc/BRIEF.md
# Reloadable Programmable Clock Divider

This block divides a parent clock down to a slower peripheral clock. The divide ratio is set through a small memory-mapped register port that has a control word and a ratio word. A new ratio written into the ratio word does not take effect straight away. It is held back until two control bits are both set: the channel's reload-force flag and the global reload trigger.

The moment both bits are seen set together, the block checks the held ratio. If the ratio is supported, the block stages it and switches to it at the end of the output period that is running, so the output never shows a shortened pulse. If the ratio is not supported, the block keeps the running ratio and sets a sticky error flag. Software clears that flag by writing a one to it.

A per-channel enable gates the output. While the enable is clear, the output is held low and the divider keeps counting in the background. Software normally clears the reload bits once the update is done. Clearing them has no effect on the ratio already in use.

Top module: `clkdiv_reload_top`

## Requirements
- R1: The ratio word sits at byte address RATIO_OFS (default 4). Its divide field is 6 bits wide at bits [13:8], and a read returns that field at the same bits with all other bits zero.
- R2: Writing the ratio word alone leaves the output period unchanged.
- R3: A new ratio is taken up only when the control word's reload-force flag (bit 1) and reload trigger (bit 8) become set together. Either bit set on its own commits nothing.
- R4: A committed ratio takes effect only at the end of the running output period. Every complete high phase therefore has the length of either the old ratio or the new one.
- R5: The output period equals the committed ratio N in parent cycles. The high phase is floor(N/2) cycles and the low phase is ceil(N/2) cycles.
- R6: The output enable is control bit 1+EN_OFS (default bit 17). While it is clear, the output stays low.
- R7: Clearing the reload-force flag and the reload trigger after a commit leaves the committed ratio unchanged.
- R8: Only the ratios 4, 5, 6 and 8 are accepted. Committing any other value keeps the previous ratio and sets the sticky error flag at control bit 31. The flag stays set until a control write with bit 31 set to one.
- R9: After reset, the committed ratio and the ratio word are both 4, the control word reads zero, and the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| clk_out | output | 1 | Gated divided clock |

## Verification
The bench builds the block with its default parameters: a 6-bit ratio field at bit 8, the ratio word at byte offset 4, an enable offset of 16 and the legal-ratio mask for 4, 5, 6 and 8. With these settings the bench can commit every supported ratio, including the odd ratio of 5 and its uneven duty cycle. It can also commit illegal values at both ends of the 6-bit range (0 and 63) and in the gap between 6 and 8 (7). The switch from a ratio of 4 to a ratio of 8 is watched phase by phase to confirm that no shortened pulse appears.

// File: rtl/clkdiv_pkg.sv
// Package: shared control-field type for the reloadable clock divider.
// Assumes one output channel per divider instance.
package clkdiv_pkg;

    // Stored control bits of the single channel.
    typedef struct packed {
        logic force_ld;   // per-channel reload-force flag
        logic trigger;    // global reload trigger
        logic enable;     // output enable
    } ctrl_t;

endpackage

// File: rtl/clkdiv_regs.sv
// Register file: holds the control and ratio words and provides a combinational read.
// It makes a one-cycle commit request on the 0->1 transition of (force & trigger),
// and a one-cycle error-clear pulse for a control write with the error bit set.
// Assumes reg_addr is a byte address and that only the two words below are decoded.
module clkdiv_regs
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int RATIO_OFS   = 4,
    parameter int RATIO_W     = 6,
    parameter int RATIO_LSB   = 8,
    parameter int CH_BIT      = 1,
    parameter int TRIG_BIT    = 8,
    parameter int EN_OFS      = 16,
    parameter int ERR_BIT     = 31,
    parameter int RESET_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               err,
    output ctrl_t              ctrl,
    output logic [RATIO_W-1:0] ratio_word,
    output logic               commit_req,
    output logic               err_clr
);
    localparam int EN_BIT = CH_BIT + EN_OFS;
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
    localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(RATIO_OFS);

    logic both_q;
    logic ctrl_hit;
    logic ratio_hit;

    // Decode the write target.
    always_comb begin
        ctrl_hit  = wr && (addr == CTRL_ADDR);
        ratio_hit = wr && (addr == RATIO_ADDR);
    end

    // Store the control and ratio words and remember the previous force&trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            ratio_word <= RATIO_W'(RESET_RATIO);
            both_q     <= 1'b0;
        end else begin
            both_q <= ctrl.force_ld & ctrl.trigger;
            if (ctrl_hit) begin
                ctrl.force_ld <= wdata[CH_BIT];
                ctrl.trigger  <= wdata[TRIG_BIT];
                ctrl.enable   <= wdata[EN_BIT];
            end
            if (ratio_hit) begin
                ratio_word <= wdata[RATIO_LSB +: RATIO_W];
            end
        end
    end

    // Commit request on the rising edge of both reload bits; error clear is write-one.
    always_comb begin
        commit_req = ctrl.force_ld & ctrl.trigger & ~both_q;
        err_clr    = ctrl_hit & wdata[ERR_BIT];
    end

    // Combinational read-back of both words.
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[CH_BIT]   = ctrl.force_ld;
            rdata[TRIG_BIT] = ctrl.trigger;
            rdata[EN_BIT]   = ctrl.enable;
            rdata[ERR_BIT]  = err;
        end else if (addr == RATIO_ADDR) begin
            rdata[RATIO_LSB +: RATIO_W] = ratio_word;
        end
    end
endmodule

// File: rtl/clkdiv_commit.sv
// Commit stage: checks a requested ratio against the legal mask.
// A legal ratio is staged with a pending flag until the counter takes it.
// An illegal ratio sets the sticky error flag; a setting event wins over a clear.
// Assumes commit_req is a single-cycle pulse.
module clkdiv_commit #(
    parameter int RATIO_W = 6,
    parameter logic [(1<<RATIO_W)-1:0] LEGAL_MASK = 'h170
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_req,
    input  logic [RATIO_W-1:0] req_ratio,
    input  logic               take,
    input  logic               err_clr,
    output logic               pend,
    output logic [RATIO_W-1:0] staged,
    output logic               err
);
    logic legal;

    // Look up the requested ratio in the legal mask.
    always_comb legal = LEGAL_MASK[req_ratio];

    // Stage legal requests, flag illegal ones, and drop pending when the counter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            staged <= '0;
            err    <= 1'b0;
        end else begin
            if (commit_req && legal) begin
                staged <= req_ratio;
                pend   <= 1'b1;
            end else if (take) begin
                pend <= 1'b0;
            end
            if (commit_req && !legal) begin
                err <= 1'b1;
            end else if (err_clr) begin
                err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/clkdiv_counter.sv
// Divider core: counts parent cycles modulo the committed ratio.
// A staged ratio is adopted only on the last cycle of a period.
// The output is registered and held low while the enable is clear.
// Assumes staged ratios are at least 2.
module clkdiv_counter #(
    parameter int RATIO_W     = 6,
    parameter int RESET_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               pend,
    input  logic [RATIO_W-1:0] staged,
    output logic               take,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [RATIO_W-1:0] cnt,
    output logic               clk_out
);
    logic               last;
    logic [RATIO_W-1:0] cnt_nx;
    logic [RATIO_W-1:0] ratio_nx;
    logic               hi_nx;

    // Next count, next ratio and next phase level.
    always_comb begin
        last     = (cnt == cur_ratio - RATIO_W'(1));
        take     = last & pend;
        cnt_nx   = last ? '0 : cnt + RATIO_W'(1);
        ratio_nx = take ? staged : cur_ratio;
        hi_nx    = (cnt_nx < (ratio_nx >> 1));
    end

    // Advance the counter, swap the ratio at the boundary, and drive the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_ratio <= RATIO_W'(RESET_RATIO);
            clk_out   <= 1'b0;
        end else begin
            cnt       <= cnt_nx;
            cur_ratio <= ratio_nx;
            clk_out   <= en & hi_nx;
        end
    end
endmodule

// File: rtl/clkdiv_reload_top.sv
// Top level of the reloadable clock divider: register file, commit stage and counter.
// Assumes a single output channel and a byte-addressed register port.
module clkdiv_reload_top
    import clkdiv_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int RATIO_OFS   = 4,
    parameter int RATIO_W     = 6,
    parameter int RATIO_LSB   = 8,
    parameter int CH_BIT      = 1,
    parameter int TRIG_BIT    = 8,
    parameter int EN_OFS      = 16,
    parameter int ERR_BIT     = 31,
    parameter int RESET_RATIO = 4,
    parameter logic [(1<<RATIO_W)-1:0] LEGAL_MASK = 'h170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              clk_out
);
    ctrl_t              ctrl;
    logic [RATIO_W-1:0] ratio_word;
    logic               commit_req;
    logic               err_clr;
    logic               err;
    logic               pend;
    logic [RATIO_W-1:0] staged;
    logic               take;
    logic [RATIO_W-1:0] cur_ratio;
    logic [RATIO_W-1:0] cnt;

    clkdiv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(32), .RATIO_OFS(RATIO_OFS), .RATIO_W(RATIO_W),
        .RATIO_LSB(RATIO_LSB), .CH_BIT(CH_BIT), .TRIG_BIT(TRIG_BIT),
        .EN_OFS(EN_OFS), .ERR_BIT(ERR_BIT), .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .err(err), .ctrl(ctrl),
        .ratio_word(ratio_word), .commit_req(commit_req), .err_clr(err_clr)
    );

    clkdiv_commit #(
        .RATIO_W(RATIO_W), .LEGAL_MASK(LEGAL_MASK)
    ) u_commit (
        .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .req_ratio(ratio_word),
        .take(take), .err_clr(err_clr), .pend(pend), .staged(staged), .err(err)
    );

    clkdiv_counter #(
        .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .pend(pend), .staged(staged),
        .take(take), .cur_ratio(cur_ratio), .cnt(cnt), .clk_out(clk_out)
    );
endmodule

// File: rtl/clkdiv_reload_chk.sv
// Checker for the reloadable clock divider, attached to the top by bind.
// Assumes it observes the internal state named in the bind below.
module clkdiv_reload_chk #(
    parameter int RATIO_W = 6,
    parameter logic [(1<<RATIO_W)-1:0] LEGAL_MASK = 'h170
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] cur_ratio,
    input logic               pend,
    input logic               en,
    input logic               clk_out,
    input logic               err,
    input logic               err_clr
);
    // R4
    ratio_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ratio) |-> ($past(cnt) == $past(cur_ratio) - RATIO_W'(1)));

    // R2
    no_silent_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> $stable(cur_ratio));

    // R8
    legal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        LEGAL_MASK[cur_ratio]);

    // R8
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    // R6
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_out);
endmodule

bind clkdiv_reload_top clkdiv_reload_chk #(
    .RATIO_W(RATIO_W), .LEGAL_MASK(LEGAL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cur_ratio(cur_ratio), .pend(pend),
    .en(ctrl.enable), .clk_out(clk_out), .err(err), .err_clr(err_clr)
);

// File: tb/clkdiv_reload_top_tb.sv
module clkdiv_reload_top_tb;
    localparam logic [3:0]  A_CTRL  = 4'h0;
    localparam logic [3:0]  A_RATIO = 4'h4;
    localparam logic [31:0] B_FORCE = 32'h1 << 1;
    localparam logic [31:0] B_TRIG  = 32'h1 << 8;
    localparam logic [31:0] B_EN    = 32'h1 << 17;
    localparam logic [31:0] B_ERR   = 32'h1 << 31;
    localparam int NVEC = 9;
    // ratio, legal, expected high cycles, expected low cycles
    localparam int VEC [NVEC][4] = '{
        '{5, 1, 2, 3}, '{3, 0, 2, 3}, '{8, 1, 4, 4}, '{7, 0, 4, 4},
        '{6, 1, 3, 3}, '{0, 0, 3, 3}, '{4, 1, 2, 2}, '{9, 0, 2, 2},
        '{63, 0, 2, 2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_out;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    clkdiv_reload_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Measure one full high phase then low phase, starting at a rising output.
    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (clk_out && guard < 100) begin @(negedge clk); guard++; end
        while (!clk_out && guard < 100) begin @(negedge clk); guard++; end
        while (clk_out && guard < 100) begin hi++; @(negedge clk); guard++; end
        while (!clk_out && guard < 100) begin lo++; @(negedge clk); guard++; end
    endtask

    initial begin
        logic [31:0] d;
        int hi, lo, run, bad;
        bit armed;
        repeat (3) @(negedge clk);
        // R9 reset state
        rd(A_CTRL, d);  check("R9 ctrl reset", int'(d), 0);
        rd(A_RATIO, d); check("R9 ratio reset", int'(d), 4 << 8);
        check("R9 output low", int'(clk_out), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 output low after reset", int'(clk_out), 0);
        wr(A_CTRL, B_EN);
        measure(hi, lo);
        check("R9 reset ratio high", hi, 2); check("R9 reset ratio low", lo, 2);

        // R1 field position and width
        wr(A_RATIO, 32'hFFFF_FFFF);
        rd(A_RATIO, d); check("R1 ratio readback", int'(d), 32'h3F00);
        wr(A_RATIO, 32'h0000_0400);

        // Vector table: commit each ratio, R5 / R8 / R7
        for (int i = 0; i < NVEC; i++) begin
            wr(A_RATIO, 32'(VEC[i][0]) << 8);
            wr(A_CTRL, B_EN | B_FORCE);
            wr(A_CTRL, B_EN | B_FORCE | B_TRIG);
            repeat (2) @(negedge clk);
            rd(A_CTRL, d);
            check("R8 error flag after commit", int'(d[31]), (VEC[i][1] == 0) ? 1 : 0);
            wr(A_CTRL, B_EN);
            if (VEC[i][1] == 0) begin
                rd(A_CTRL, d); check("R8 error flag sticky", int'(d[31]), 1);
                wr(A_CTRL, B_EN | B_ERR);
                rd(A_CTRL, d); check("R8 error flag cleared", int'(d[31]), 0);
            end
            repeat (20) @(negedge clk);
            measure(hi, lo);
            check("R5/R7 high phase", hi, VEC[i][2]);
            check("R5/R7 low phase", lo, VEC[i][3]);
        end

        // R2 write without reload; R3 trigger alone and force alone
        wr(A_RATIO, 32'h0000_0800);
        repeat (20) @(negedge clk);
        measure(hi, lo); check("R2 ratio write alone", hi + lo, 4);
        wr(A_CTRL, B_EN | B_TRIG);
        repeat (20) @(negedge clk);
        measure(hi, lo); check("R3 trigger without force", hi + lo, 4);
        wr(A_CTRL, B_EN | B_FORCE);
        repeat (20) @(negedge clk);
        measure(hi, lo); check("R3 force without trigger", hi + lo, 4);

        // R4 no runt across the switch from 4 to 8
        wr(A_CTRL, B_EN | B_FORCE | B_TRIG);
        run = 0; bad = 0; armed = 0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (!clk_out) begin
                if (armed && run != 0 && run != 2 && run != 4) bad++;
                armed = 1; run = 0;
            end else begin
                run++;
            end
        end
        check("R4 runt-free high phases", bad, 0);
        wr(A_CTRL, B_EN);
        repeat (10) @(negedge clk);
        measure(hi, lo); check("R7 ratio kept after clear", hi + lo, 8);

        // R6 enable clear holds output low
        wr(A_CTRL, 32'h0);
        repeat (2) @(negedge clk);
        bad = 0;
        for (int c = 0; c < 24; c++) begin
            @(negedge clk);
            if (clk_out) bad++;
        end
        check("R6 output low while disabled", bad, 0);
        wr(A_CTRL, B_EN);
        measure(hi, lo); check("R6 output back after enable", hi + lo, 8);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule